// File: doc/BRIEF.md
# PAM-3 Transmitter Test Pattern Generator

This block drives a ternary (+1, 0, -1) symbol stream straight into the symbol input of a single-pair transmitter, so that the line driver can be measured on its own. A 2-bit mode input picks one of three streams. The first is idle, which is all zeros. The second is a one-symbol alternation of +1 and -1. The third is a run alternation: ten +1 symbols, then ten -1 symbols, repeated.

Symbols are paced by a strobe taken from the system clock with a fractional accumulator. At each system clock edge the accumulator adds NUM modulo DEN, and a carry out marks a symbol slot. With the defaults (3 of 4) and a 10 MHz clock, this gives the nominal 7.5 Msymbol/s rate, a period of about 133.333 ns.

Each output symbol comes with a one-cycle valid pulse. A mode change is held back until the running pattern reaches its end. Every pattern then starts again from +1.

Top module: `ternary_pattern_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, `sym_valid_o` is 0 and `sym_o` is 2'b00. The first valid symbol after reset is 0, and the mode input is sampled at that symbol.
- R2: After reset is released, `sym_valid_o` takes the values 0,1,1,1 repeating, one value per clock. These are the registered values after the 1st, 2nd, 3rd, 4th... rising edge with reset low. Every window of four cycles holds exactly three valid pulses.
- R3: Symbol codes are 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1. Code 2'b10 never appears.
- R4: Mode 2'b01 (alternation) emits +1, -1, +1, -1, ... on successive valid symbols.
- R5: Mode 2'b10 (run alternation) emits RUN_LEN (default 10) +1 symbols, then RUN_LEN -1 symbols, and repeats.
- R6: Mode 2'b00 (idle) emits 0 on every valid symbol, and the valid strobe keeps its 3-of-4 cadence.
- R7: A change of `mode_i` takes effect only after the last symbol of the running pattern. That is the -1 of an alternation pair, the last -1 of a run period, or any idle symbol. The new pattern begins with +1.
- R8: The reserved mode 2'b11 behaves as idle.
- R9: `sym_o` changes only in cycles where `sym_valid_o` is high. Between pulses it holds the last symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 10 MHz for 3/4 pacing) |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 idle, 01 alternation, 10 run alternation, 11 idle |
| sym_o | output | 2 | Signed ternary symbol code |
| sym_valid_o | output | 1 | One-cycle pulse marking a new symbol |

## Verification
The outputs are registered. The first cycle after reset release therefore shows valid low, and a mode sampled at a boundary symbol appears on the next valid pulse. The bench samples 1 ns after each rising edge. It collects symbols only on cycles where valid is high, so each comparison lines up with the pattern position whatever the strobe gaps are. The cadence check, the reset check and the hold-between-pulses check are done per cycle, against the 0,1,1,1 phase counted from the release edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_ALT  = 2'b01,
    MODE_RUN  = 2'b10,
    MODE_RSVD = 2'b11
  } tpg_mode_e;

  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_NEG  = 2'b11;
endpackage

// File: rtl/tpg_rate_accum.sv
// Fractional symbol strobe: adds NUM modulo DEN each clock, ticks on carry.
module tpg_rate_accum #(
  parameter int NUM = 3,
  parameter int DEN = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int SUM_W = $clog2(2 * DEN);

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] acc_d;

  always_comb begin
    sum    = acc_q + SUM_W'(NUM);
    tick_o = (sum >= SUM_W'(DEN));
    acc_d  = tick_o ? (sum - SUM_W'(DEN)) : sum;
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end
endmodule

// File: rtl/tpg_sequencer.sv
// Holds the active pattern and its position; swaps mode only at a boundary.
module tpg_sequencer
  import tpg_pkg::*;
#(
  parameter int RUN_LEN = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] mode_i,
  output logic [1:0] sym_o
);
  localparam int RUN_PER = 2 * RUN_LEN;
  localparam int CNT_W   = $clog2(RUN_PER);

  tpg_mode_e        act_q;
  logic [CNT_W-1:0] pos_q;
  logic             last;

  always_comb begin
    case (act_q)
      MODE_ALT: begin
        sym_o = pos_q[0] ? SYM_NEG : SYM_POS;
        last  = (pos_q == CNT_W'(1));
      end
      MODE_RUN: begin
        sym_o = (pos_q < CNT_W'(RUN_LEN)) ? SYM_POS : SYM_NEG;
        last  = (pos_q == CNT_W'(RUN_PER - 1));
      end
      default: begin
        sym_o = SYM_ZERO;
        last  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= MODE_IDLE;
      pos_q <= '0;
    end else if (tick_i) begin
      if (last) begin
        act_q <= tpg_mode_e'(mode_i);
        pos_q <= '0;
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tpg_out_reg.sv
// Output stage: symbol held between strobes, valid is a registered pulse.
module tpg_out_reg #(
  parameter int SYM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) sym_o <= sym_i;
    end
  end
endmodule

// File: rtl/ternary_pattern_gen.sv
module ternary_pattern_gen #(
  parameter int RATE_NUM = 3,
  parameter int RATE_DEN = 4,
  parameter int RUN_LEN  = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  output logic [1:0] sym_o,
  output logic       sym_valid_o
);
  logic       tick;
  logic [1:0] seq_sym;

  tpg_rate_accum #(.NUM(RATE_NUM), .DEN(RATE_DEN)) u_rate (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  tpg_sequencer #(.RUN_LEN(RUN_LEN)) u_seq (
    .clk(clk), .rst(rst), .tick_i(tick), .mode_i(mode_i), .sym_o(seq_sym)
  );

  tpg_out_reg #(.SYM_W(2)) u_out (
    .clk(clk), .rst(rst), .tick_i(tick), .sym_i(seq_sym),
    .sym_o(sym_o), .valid_o(sym_valid_o)
  );
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] sym_o,
  input logic       sym_valid_o
);
  logic       rst_q = 1'b0;
  logic       armed = 1'b0;
  logic [3:0] hist  = 4'b0;
  logic [2:0] age   = 3'd0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      armed <= 1'b0;
      hist  <= '0;
      age   <= '0;
    end else begin
      armed <= 1'b1;
      if (armed) begin
        hist <= {hist[2:0], sym_valid_o};
        if (age != 3'd4) age <= age + 3'd1;
      end
    end
  end

  // R1: outputs cleared after a reset edge
  always @(posedge clk) begin
    if (rst_q) assert_reset_clear_R1: assert (!sym_valid_o && sym_o == 2'b00);
  end

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    sym_o != 2'b10);

  assert_no_double_gap_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !sym_valid_o |=> sym_valid_o);

  assert_rate_window_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (age == 3'd4) |-> ($countones(hist) == 3));

  assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    !sym_valid_o |-> $stable(sym_o));
endmodule

bind ternary_pattern_gen tpg_checker u_chk (
  .clk(clk), .rst(rst), .sym_o(sym_o), .sym_valid_o(sym_valid_o)
);

// File: tb/tb_ternary_pattern_gen.sv
`timescale 1ns/1ps
module tb_ternary_pattern_gen;
  localparam logic [1:0] P = 2'b01, Z = 2'b00, N = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic [1:0] sym;
  logic       valid;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ternary_pattern_gen dut (
    .clk(clk), .rst(rst), .mode_i(mode), .sym_o(sym), .sym_valid_o(valid)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst  = 1'b1;
    mode = m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic next_sym(output logic [1:0] s);
    int n = 0;
    s = 2'bxx;
    while (n < 8) begin
      @(posedge clk); #1;
      if (valid) begin s = sym; break; end
      n++;
    end
  endtask

  // R1, R2: reset state and strobe cadence
  task automatic t_reset_cadence;
    @(negedge clk); rst = 1'b1; mode = 2'b01;
    @(posedge clk); #1;
    check("R1 valid in reset", {1'b0, valid}, 2'b00);
    check("R1 sym in reset", sym, Z);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      check("R2 cadence", {1'b0, valid}, {1'b0, (i % 4) != 0});
    end
  endtask

  // R1, R4, R3: alternation
  task automatic t_alt;
    logic [1:0] s;
    do_reset(2'b01);
    next_sym(s); check("R1 first symbol zero", s, Z);
    for (int i = 0; i < 10; i++) begin
      next_sym(s); check("R4 alternation", s, (i % 2 == 0) ? P : N);
    end
  endtask

  // R5: run alternation over two periods
  task automatic t_run;
    logic [1:0] s;
    do_reset(2'b10);
    next_sym(s); check("R1 first symbol zero", s, Z);
    for (int i = 0; i < 40; i++) begin
      next_sym(s); check("R5 run pattern", s, ((i % 20) < 10) ? P : N);
    end
  endtask

  // R6: idle zeros with running strobe
  task automatic t_idle;
    logic [1:0] s;
    int pulses = 0;
    do_reset(2'b00);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #1;
      if (valid) begin pulses++; check("R6 idle symbol", sym, Z); end
    end
    check("R6 strobe count", pulses[1:0], 2'(12 % 4));
    check("R6 strobe count hi", {1'b0, pulses == 12}, 2'b01);
    next_sym(s); check("R6 idle symbol after window", s, Z);
  endtask

  // R8: reserved mode acts as idle
  task automatic t_reserved;
    logic [1:0] s;
    do_reset(2'b11);
    for (int i = 0; i < 8; i++) begin
      next_sym(s); check("R8 reserved as idle", s, Z);
    end
  endtask

  // R7: mode changes wait for the pattern boundary
  task automatic t_switch;
    logic [1:0] s;
    do_reset(2'b10);
    next_sym(s);
    for (int i = 0; i < 5; i++) begin next_sym(s); check("R7 run before switch", s, P); end
    mode = 2'b01;
    for (int i = 5; i < 20; i++) begin
      next_sym(s); check("R7 run completes", s, (i < 10) ? P : N);
    end
    next_sym(s); check("R7 new pattern starts +1", s, P);
    mode = 2'b10;
    next_sym(s); check("R7 alternation pair completes", s, N);
    for (int i = 0; i < 10; i++) begin next_sym(s); check("R7 run after switch", s, P); end
    next_sym(s); check("R7 run then -1", s, N);
    mode = 2'b00;
    for (int i = 0; i < 9; i++) begin next_sym(s); check("R7 run held to end", s, N); end
    next_sym(s); check("R7 idle after run", s, Z);
  endtask

  // R9, R3: symbol held between pulses, only legal codes
  task automatic t_hold;
    logic [1:0] last_s = Z;
    do_reset(2'b01);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (valid) last_s = sym;
      else check("R9 hold between pulses", sym, last_s);
      check("R3 legal code", {1'b0, sym == 2'b10}, 2'b00);
    end
  endtask

  initial begin
    t_reset_cadence();
    t_alt();
    t_run();
    t_idle();
    t_reserved();
    t_switch();
    t_hold();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule